// File: doc/BRIEF.md
# Shaped-Distribution Pseudo-Random Noise Generator

This block is a parameterised noise source that offers selectable output statistics. Its core is a maximal-length linear feedback shift register (LFSR) whose width sets the output word width. A second, shorter maximal-length LFSR runs on every clock. Its lowest bit serves as an irregular stepping enable, so the main register advances on a non-uniform subset of clocks.

Each time the main register steps, the word it held before the step is scaled down by a right shift. The scaled word is pushed into a shift buffer that holds W-1 entries. An adder tree sums the whole buffer into a registered Gaussian-family output. By the central limit theorem, this sum approaches a bell shape centred near mid-scale. In the bimodal mode, the inverted top bit of the previous Gaussian output is folded into the main register's feedback. This pushes the sequence away from the mean.

A second output carries the uniform family. It presents either the raw register word, or the floor of the mean of the current word and the word held before the most recent step. The averaged form gives a triangular, non-uniform spread. Both outputs are valid on every cycle.

Top module: `shaped_noise_gen`

## Requirements
- R1: A synchronous active-high reset loads the main register with its seed (1 by default) and the stepping register with its own seed, and clears the buffer. While reset is held, u_noise equals the main seed and g_noise is 0.
- R2: The stepping register has V bits and a maximal-length polynomial, and it advances every clock. The main register steps on the clock edges where the stepping register's bit 0 is 1. So the pattern of steps repeats every 2^V-1 clocks, with exactly 2^(V-1) steps in each repeat.
- R3: When not in bimodal mode, the main register walks through all 2^W-1 nonzero W-bit values before it returns to its seed. In the plain modes, each value appears on u_noise.
- R4: The main register, and therefore u_noise, keeps its value on clocks without a step. On clocks with a step it changes value whenever no feedback is injected.
- R5: On each step, the pre-step main word shifted right by ceil(log2(W-1)) enters the front of a W-1 entry buffer, and the oldest entry is dropped. One clock later, g_noise equals the sum of all entries. The sum never exceeds W bits.
- R6: g_noise changes only on the clock that follows a step.
- R7: The distribution mode has four values: Gaussian, bimodal, uniform, non-uniform. In non-uniform mode, u_noise is floor((current + previous)/2). Here previous is the main word before the latest step, and it equals the seed after reset. In every other mode, u_noise is the main word itself.
- R8: In bimodal mode, the inverse of g_noise bit W-1 is XORed into the main feedback bit. The resulting sequence differs from the Gaussian-mode sequence, while the stepping cadence stays the same.
- R9: The main register never holds zero, and u_noise is never zero. If an injected feedback bit would produce an all-zero next state, the value 1 is loaded instead.
- R10: When W-1 is a power of two (for example W=9), the mean of g_noise over one full main period is within 2^W/32 of 2^(W-1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| u_noise | output | W | Uniform-family output: raw word, or averaged word in non-uniform mode |
| g_noise | output | W | Gaussian-family output: registered buffer sum, bimodal when feedback is enabled |

## Verification
A wrong stepping polynomial shows up on u_noise within one stepping period (2^V-1 clocks). The step pattern loses its repeat, or it shows the wrong count of steps. A wrong main polynomial shows up as a repeated or skipped value before 2^W-1 steps have passed. A buffer or scaling fault appears on g_noise one clock after the first affected step, because each sum is rebuilt from the observed u_noise history. A fault in the averaging register, or in the bimodal feedback, appears on u_noise at the first step that uses it.

// File: rtl/noise_pkg.sv
`timescale 1ns/1ps
package noise_pkg;

  typedef enum logic [1:0] {
    DIST_GAUSS      = 2'd0,
    DIST_BIMODAL    = 2'd1,
    DIST_UNIFORM    = 2'd2,
    DIST_NONUNIFORM = 2'd3
  } dist_mode_e;

  // Feedback tap mask for a maximal-length Fibonacci register of n bits.
  // Bit k set means state[k] takes part in the parity.
  function automatic logic [31:0] tap_mask(input int n);
    logic [31:0] m;
    case (n)
      2:  m = 32'h0000_0003;
      3:  m = 32'h0000_0006;
      4:  m = 32'h0000_000C;
      5:  m = 32'h0000_0014;
      6:  m = 32'h0000_0030;
      7:  m = 32'h0000_0060;
      8:  m = 32'h0000_00B8;
      9:  m = 32'h0000_0110;
      10: m = 32'h0000_0240;
      11: m = 32'h0000_0500;
      12: m = 32'h0000_0829;
      13: m = 32'h0000_100D;
      14: m = 32'h0000_2015;
      15: m = 32'h0000_6000;
      16: m = 32'h0000_D008;
      17: m = 32'h0001_2000;
      18: m = 32'h0002_0400;
      19: m = 32'h0004_0023;
      20: m = 32'h0009_0000;
      21: m = 32'h0014_0000;
      22: m = 32'h0030_0000;
      23: m = 32'h0042_0000;
      24: m = 32'h00E1_0000;
      default: m = 32'h0000_0000;
    endcase
    return m;
  endfunction

  // Right-shift applied to each buffer entry so that depth entries fit in W bits.
  function automatic int entry_shift(input int depth);
    int s;
    s = 0;
    while ((1 << s) < depth) s++;
    return s;
  endfunction

  // Leaves of the adder tree: depth rounded up to a power of two.
  function automatic int tree_leaves(input int depth);
    return 1 << entry_shift(depth);
  endfunction

endpackage

// File: rtl/lfsr_core.sv
`timescale 1ns/1ps
module lfsr_core #(
  parameter int          N    = 8,
  parameter logic [31:0] SEED = 32'h1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  input  logic         inj,
  output logic [N-1:0] state
);
  localparam logic [31:0] TAPS_ALL = noise_pkg::tap_mask(N);
  localparam logic [N-1:0] TAPS    = TAPS_ALL[N-1:0];
  localparam logic [N-1:0] ONE     = {{(N-1){1'b0}}, 1'b1};
  localparam logic [N-1:0] SEED_N  = (SEED[N-1:0] == '0) ? ONE : SEED[N-1:0];

  logic         fb;
  logic [N-1:0] shifted;
  logic [N-1:0] nxt;
  logic         zero_hit;

  always_comb begin
    fb       = (^(state & TAPS)) ^ inj;
    shifted  = {state[N-2:0], fb};
    zero_hit = (shifted == '0);
    nxt      = zero_hit ? ONE : shifted;
  end

  always_ff @(posedge clk) begin
    if (rst)      state <= SEED_N;
    else if (adv) state <= nxt;
  end

  // R9: the register never holds the all-zero lockup state
  p_nonzero_state_r9: assert property (@(posedge clk) disable iff (rst)
    state != '0);

  // R9: the zero guard is only ever needed when feedback is injected
  p_zero_only_injected_r9: assert property (@(posedge clk) disable iff (rst)
    (adv && zero_hit) |-> inj);

  // R4: no step, no change
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(state));

  // R4: an uninjected step always moves to a different state
  p_move_r4: assert property (@(posedge clk) disable iff (rst)
    (adv && !inj) |=> state != $past(state));

endmodule

// File: rtl/shift_sum.sv
`timescale 1ns/1ps
module shift_sum #(
  parameter int W     = 8,
  parameter int DEPTH = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic [W-1:0] sum_q
);
  localparam int SHIFT  = noise_pkg::entry_shift(DEPTH);
  localparam int LEAVES = noise_pkg::tree_leaves(DEPTH);
  localparam int NODES  = 2 * LEAVES - 1;
  localparam int SW     = W + SHIFT + 1;

  logic [W-1:0]  scaled;
  logic [W-1:0]  stage [DEPTH];
  logic [SW-1:0] node  [NODES];
  logic [SW-1:0] root;
  logic          overflow;
  logic          pushed_d;

  assign scaled = din >> SHIFT;

  // Shift buffer: entry 0 is the newest.
  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    if (k == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst)       stage[k] <= '0;
        else if (push) stage[k] <= scaled;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst)       stage[k] <= '0;
        else if (push) stage[k] <= stage[k-1];
      end
    end
  end

  // Leaves of the adder tree, padded with zeros to a power of two.
  for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
    if (i < DEPTH) begin : g_used
      assign node[LEAVES-1+i] = SW'(stage[i]);
    end else begin : g_pad
      assign node[LEAVES-1+i] = '0;
    end
  end

  // Internal nodes: node i sums its two children.
  for (genvar i = 0; i < LEAVES - 1; i++) begin : g_add
    assign node[i] = node[2*i+1] + node[2*i+2];
  end

  assign root     = node[0];
  assign overflow = |root[SW-1:W];

  always_ff @(posedge clk) begin
    if (rst) begin
      pushed_d <= 1'b0;
      sum_q    <= '0;
    end else begin
      pushed_d <= push;
      if (pushed_d) sum_q <= root[W-1:0];
    end
  end

  // R5: the scaled entries never carry past W bits
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    !overflow);

  // R6: the Gaussian output moves only one clock after a push
  p_sum_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !pushed_d |=> $stable(sum_q));

endmodule

// File: rtl/shaped_noise_gen.sv
`timescale 1ns/1ps
module shaped_noise_gen
  import noise_pkg::*;
#(
  parameter int          W         = 8,
  parameter int          V         = 5,
  parameter dist_mode_e  MODE      = DIST_GAUSS,
  parameter logic [31:0] MAIN_SEED = 32'h1,
  parameter logic [31:0] STEP_SEED = 32'h1
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] u_noise,
  output logic [W-1:0] g_noise
);
  localparam int          DEPTH    = W - 1;
  localparam bit          BIMODAL  = (MODE == DIST_BIMODAL);
  localparam bit          AVERAGED = (MODE == DIST_NONUNIFORM);
  localparam logic [W-1:0] ONE_W   = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] SEED_W  = (MAIN_SEED[W-1:0] == '0) ? ONE_W : MAIN_SEED[W-1:0];

  logic [V-1:0] step_state;
  logic         step_en;
  logic         main_inj;
  logic [W-1:0] main_word;
  logic [W-1:0] prev_word;
  logic [W-1:0] avg_word;

  // Irregular stepping source
  lfsr_core #(.N(V), .SEED(STEP_SEED)) step_i (
    .clk   (clk),
    .rst   (rst),
    .adv   (1'b1),
    .inj   (1'b0),
    .state (step_state)
  );

  assign step_en  = step_state[0];
  assign main_inj = BIMODAL ? ~g_noise[W-1] : 1'b0;

  // Main word source
  lfsr_core #(.N(W), .SEED(MAIN_SEED)) main_i (
    .clk   (clk),
    .rst   (rst),
    .adv   (step_en),
    .inj   (main_inj),
    .state (main_word)
  );

  always_ff @(posedge clk) begin
    if (rst)          prev_word <= SEED_W;
    else if (step_en) prev_word <= main_word;
  end

  assign avg_word = (main_word >> 1) + (prev_word >> 1)
                  + {{(W-1){1'b0}}, main_word[0] & prev_word[0]};

  always_comb u_noise = AVERAGED ? avg_word : main_word;

  // Gaussian path: buffer shifts on the same clocks the main word steps
  shift_sum #(.W(W), .DEPTH(DEPTH)) sum_i (
    .clk   (clk),
    .rst   (rst),
    .push  (step_en),
    .din   (main_word),
    .sum_q (g_noise)
  );

  // R2: the stepping source stays out of its lockup state
  p_stepper_live_r2: assert property (@(posedge clk) disable iff (rst)
    step_state != '0);

  // R9: the uniform port never shows zero
  p_out_nonzero_r9: assert property (@(posedge clk) disable iff (rst)
    u_noise != '0);

  // R4: the uniform port is frozen on clocks without a step
  p_step_cadence_r4: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> $stable(u_noise));

  // R7: the averaged word lies between its two operands
  p_avg_bounds_r7: assert property (@(posedge clk) disable iff (rst)
    AVERAGED |-> ((u_noise >= main_word || u_noise >= prev_word) &&
                  (u_noise <= main_word || u_noise <= prev_word)));

endmodule

// File: tb/shaped_noise_gen_tb_top.sv
`timescale 1ns/1ps
module noise_model_mon #(
  parameter int    W            = 9,
  parameter bit    CHECK_PERIOD = 1'b1,
  parameter string NAME         = "mon"
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] u,
  input  logic [W-1:0] g,
  output int           n_chk,
  output int           n_bad,
  output bit           period_ok
);
  function automatic int shift_for(input int d);
    int s;
    s = 0;
    while ((1 << s) < d) s++;
    return s;
  endfunction

  localparam int D  = W - 1;
  localparam int SH = shift_for(D);
  localparam int P  = (1 << W) - 1;

  int chk_r = 0;
  int bad_r = 0;
  bit per_r = 1'b0;
  int bufm [D];
  int exp_sum;
  int last_u;
  int first_u;
  int adv_n;
  int dup;
  bit seen [1 << W];

  assign n_chk     = chk_r;
  assign n_bad     = bad_r;
  assign period_ok = per_r;

  task automatic tally(input bit ok, input string req, input int act, input int exp);
    chk_r++;
    if (!ok) begin
      bad_r++;
      $display("FAIL %s %s actual=%0d expected=%0d", NAME, req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst) begin
      for (int k = 0; k < D; k++) bufm[k] = 0;
      for (int k = 0; k < (1 << W); k++) seen[k] = 1'b0;
      exp_sum = 0;
      last_u  = int'(u);
      first_u = int'(u);
      seen[first_u] = 1'b1;
      adv_n   = 0;
      dup     = 0;
    end else begin
      tally(int'(g) == exp_sum, "R5/R6 gaussian sum", int'(g), exp_sum);
      tally(u != '0, "R9 nonzero word", int'(u), 1);
      if (int'(u) != last_u) begin
        for (int k = D - 1; k > 0; k--) bufm[k] = bufm[k-1];
        bufm[0] = last_u >> SH;
        exp_sum = 0;
        for (int k = 0; k < D; k++) exp_sum += bufm[k];
        adv_n++;
        if (CHECK_PERIOD) begin
          if (adv_n < P) begin
            if (seen[u]) dup++;
            seen[u] = 1'b1;
          end else if (adv_n == P) begin
            tally(dup == 0, "R3 no repeat inside period", dup, 0);
            tally(int'(u) == first_u, "R3 return to seed", int'(u), first_u);
            per_r = (dup == 0) && (int'(u) == first_u);
          end
        end
        last_u = int'(u);
      end
    end
  end
endmodule

module shaped_noise_gen_tb_top;
  import noise_pkg::*;

  localparam int WA     = 9;
  localparam int VA     = 4;
  localparam int WB     = 5;
  localparam int VB     = 3;
  localparam int PSTEP  = (1 << VA) - 1;
  localparam int N_CYC  = 6000;
  localparam int N_MEAN = 4 * ((1 << WA) - 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [WA-1:0] u_i, g_i, u_av, g_av, u_bm, g_bm;
  logic [WB-1:0] u_w, g_w;

  shaped_noise_gen #(.W(WA), .V(VA), .MODE(DIST_GAUSS)) dut_i (
    .clk(clk), .rst(rst), .u_noise(u_i), .g_noise(g_i));
  shaped_noise_gen #(.W(WA), .V(VA), .MODE(DIST_NONUNIFORM)) dut_av (
    .clk(clk), .rst(rst), .u_noise(u_av), .g_noise(g_av));
  shaped_noise_gen #(.W(WA), .V(VA), .MODE(DIST_BIMODAL)) dut_bm (
    .clk(clk), .rst(rst), .u_noise(u_bm), .g_noise(g_bm));
  shaped_noise_gen #(.W(WB), .V(VB), .MODE(DIST_UNIFORM)) dut_w (
    .clk(clk), .rst(rst), .u_noise(u_w), .g_noise(g_w));

  int  c_i, b_i, c_bm, b_bm, c_w, b_w;
  bit  p_i, p_bm, p_w;

  noise_model_mon #(.W(WA), .CHECK_PERIOD(1'b1), .NAME("gauss")) mon_i (
    .clk(clk), .rst(rst), .u(u_i), .g(g_i), .n_chk(c_i), .n_bad(b_i), .period_ok(p_i));
  noise_model_mon #(.W(WA), .CHECK_PERIOD(1'b0), .NAME("bimodal")) mon_bm (
    .clk(clk), .rst(rst), .u(u_bm), .g(g_bm), .n_chk(c_bm), .n_bad(b_bm), .period_ok(p_bm));
  noise_model_mon #(.W(WB), .CHECK_PERIOD(1'b1), .NAME("narrow")) mon_w (
    .clk(clk), .rst(rst), .u(u_w), .g(g_w), .n_chk(c_w), .n_bad(b_w), .period_ok(p_w));

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    total += c_i + c_bm + c_w;
    bad   += b_i + b_bm + b_w;
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    bit pat [2*PSTEP];
    int last_i, last_b, prevw, exp_av, ones, rep_bad;
    int diff, cad_bad, nadv, nsamp, prev_adv;
    longint gsum;
    int mean;

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state on both ports of every instance
    check(u_i == 9'd1, "R1 gauss u_noise seed", int'(u_i), 1);
    check(g_i == '0, "R1 gauss g_noise cleared", int'(g_i), 0);
    check(u_av == 9'd1, "R1 averaged u_noise seed", int'(u_av), 1);
    check(g_bm == '0, "R1 bimodal g_noise cleared", int'(g_bm), 0);
    check(u_w == 5'd1, "R1 narrow u_noise seed", int'(u_w), 1);
    last_i = int'(u_i);
    last_b = int'(u_bm);
    prevw  = 1;
    diff = 0; cad_bad = 0; nadv = 0; nsamp = 0; prev_adv = 0; gsum = 0;
    #1 rst = 1'b0;

    for (int cyc = 0; cyc < N_CYC; cyc++) begin
      bit adv_i, adv_b;
      @(negedge clk);
      adv_i = (int'(u_i) != last_i);
      adv_b = (int'(u_bm) != last_b);
      if (cyc < 2 * PSTEP) pat[cyc] = adv_i;
      if (adv_i != adv_b) cad_bad++;
      if (u_bm != u_i) diff++;
      // R10: sample the Gaussian sum one clock after each step
      if (prev_adv != 0 && nadv > 16 && nsamp < N_MEAN) begin
        gsum += longint'(g_i);
        nsamp++;
      end
      if (adv_i) begin
        prevw = last_i;
        nadv++;
      end
      exp_av = (int'(u_i) + prevw) / 2;
      // R7: averaged word against the plain sequence of an identical register
      check(int'(u_av) == exp_av, "R7 averaged word", int'(u_av), exp_av);
      prev_adv = adv_i ? 1 : 0;
      last_i = int'(u_i);
      last_b = int'(u_bm);
    end

    // R2 and R4: stepping pattern repeats every 2^V-1 clocks with 2^(V-1) steps
    ones = 0;
    rep_bad = 0;
    for (int k = 0; k < PSTEP; k++) begin
      if (pat[k]) ones++;
      if (pat[k] != pat[k + PSTEP]) rep_bad++;
    end
    check(rep_bad == 0, "R2 step pattern period", rep_bad, 0);
    check(ones == (1 << (VA - 1)), "R2/R4 steps per period", ones, 1 << (VA - 1));

    // R3: full period reached on both plain instances
    check(p_i, "R3 main period W=9", int'(p_i), 1);
    check(p_w, "R3 main period W=5", int'(p_w), 1);

    // R8: bimodal feedback changes the sequence but not the cadence
    check(diff > 0, "R8 bimodal sequence departs", diff, 1);
    check(cad_bad == 0, "R8 bimodal cadence", cad_bad, 0);

    // R10: mean near mid-scale
    check(nsamp == N_MEAN, "R10 sample count", nsamp, N_MEAN);
    mean = (nsamp > 0) ? int'(gsum / longint'(nsamp)) : 0;
    check(mean >= (1 << (WA - 1)) - (1 << WA) / 32 && mean <= (1 << (WA - 1)) + (1 << WA) / 32,
          "R10 gaussian mean", mean, 1 << (WA - 1));

    finished = 1'b1;
    report();
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      report();
      $finish;
    end
  end

endmodule